// File: doc/BRIEF.md
# Nonvolatile Memory Controller with Write Unlock

This block fronts a small byte-wide nonvolatile data store. A CPU reaches it through three registers: a control/status register, an address register and a data register. Reads are single-shot: a read strobe copies the addressed byte into the data register on the next clock edge. Programming is protected by a two-step unlock. Software first sets an arm bit, which hardware drops again on its own. While the arm bit is still up, software writes the start bit. A program operation then runs for a fixed, mode-dependent number of clock ticks, and the busy flag stays up until it ends.

There are three program modes: atomic (the byte takes the new data), erase (the byte becomes 0xFF) and write-only (the new data is ANDed into the stored byte). The block also drives a level ready interrupt, and a stall request that holds the CPU for a few cycles after a start or a read. The storage cells are modelled by an internal register array that is cleared to 0xFF at power-on. A power-on reset clears everything. A separate system reset clears the control side but does not disturb a program operation that is already running.

The register port is a plain one-cycle write strobe with a select code, and the registers are always visible. No data stream crosses the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `nvm_ctrl`

## Requirements
- R1: After power-on reset, ctrl_q, addr_q, data_q, irq and stall are all 0. Every storage byte reads 0xFF.
- R2: A control write with bit 2 (arm) set makes ctrl_q[2] read 1 for exactly ARM_WINDOW (4) cycles after that write. It reads 0 from the next cycle on.
- R3: A control write with bit 1 (start) set launches a program operation only if the arm bit was 1 before that write. After a launch, ctrl_q[1] (busy) reads 1 for exactly ATOMIC_TICKS cycles in mode 00, or SPLIT_TICKS cycles in modes 01 and 10. A start written while the arm bit is 0 leaves busy at 0.
- R4: The mode is held in control bits 5:4. Mode 00 stores the data register value. Mode 01 stores 0xFF. Mode 10 stores the old byte AND the data register value. The address and data are taken at the launch.
- R5: A start in mode 11 does not set busy and does not consume the arm bit.
- R6: While busy is 1, writes to control bits 5:4 are ignored.
- R7: When busy falls, the operation's result is visible to a later read. Data register writes made during the operation do not change what is stored.
- R8: A control write with bit 0 set loads data_q with the addressed byte one edge later. While busy, this read is refused (data_q is unchanged), and writes to the address register are ignored.
- R9: While flash_busy is 1, a start is refused and busy stays 0.
- R10: stall is 1 for 2 cycles after a launch and for 4 cycles after an accepted read. Otherwise it is 0.
- R11: irq is 1 exactly when control bit 3 (interrupt enable) is 1 and busy is 0.
- R12: A system reset while busy keeps the mode bits and lets the operation finish and store its result. A system reset while idle returns the mode bits to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the program timing tick |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 none |
| reg_wdata | input | 8 | Register write data |
| flash_busy | input | 1 | Flash self-programming in progress; blocks starts |
| ctrl_q | output | 8 | Control/status: [5:4] mode, [3] irq enable, [2] arm, [1] busy, others 0 |
| addr_q | output | AW | Address register |
| data_q | output | 8 | Data register |
| irq | output | 1 | Ready interrupt level |
| stall | output | 1 | CPU stall request |

## Verification
The assertions assume the following about the inputs:
- rst_n is released only after por_n.
- reg_sel carries one of the four defined codes whenever reg_we is high.
- flash_busy is a clean synchronous level.

The bench drives every input on the falling clock edge, one register write per cycle. It always writes the arm bit and the start bit in separate writes, so the arm window and its consumption are never in conflict. It pulses the system reset only on falling edges, after power-on reset has been released.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_RSVD   = 2'b11
  } nvm_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int B_READ  = 0;
  localparam int B_START = 1;
  localparam int B_ARM   = 2;
  localparam int B_RIE   = 3;
  localparam int B_MLO   = 4;
  localparam int B_MHI   = 5;

  // result of one program operation on a stored byte
  function automatic logic [7:0] apply_op(nvm_mode_e m, logic [7:0] old_b, logic [7:0] new_b);
    case (m)
      MODE_ATOMIC: return new_b;
      MODE_ERASE:  return 8'hFF;
      MODE_WRITE:  return old_b & new_b;
      default:     return old_b;
    endcase
  endfunction

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic arm_set,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt <= '0;
    else if (!rst_n || consume) cnt <= '0;
    else if (arm_set)          cnt <= CW'(WIN);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign armed = (cnt != '0);

  // R2: setting the arm bit makes it visible on the next cycle
  p_arm_set_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (arm_set && !consume) |=> armed);

  // R2: the window closes by itself when it runs out
  p_arm_expires_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cnt == CW'(1) && !arm_set && !consume) |=> !armed);

endmodule

// File: rtl/nvm_prog_engine.sv
module nvm_prog_engine
  import nvm_pkg::*;
#(
  parameter int ATOMIC_TICKS = 26368,
  parameter int SPLIT_TICKS  = 13960,
  parameter int AW           = 6
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          launch,
  input  nvm_mode_e     launch_mode,
  input  logic [AW-1:0] launch_addr,
  input  logic [7:0]    launch_data,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output nvm_mode_e     commit_mode,
  output logic [7:0]    commit_data
);
  localparam int MAXT = (ATOMIC_TICKS > SPLIT_TICKS) ? ATOMIC_TICKS : SPLIT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic          busy_q;

  // only power-on reset touches the engine, so a system reset never cuts an operation short
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q      <= 1'b0;
      cnt         <= '0;
      commit_addr <= '0;
      commit_mode <= MODE_ATOMIC;
      commit_data <= '0;
    end else if (launch) begin
      busy_q      <= 1'b1;
      cnt         <= (launch_mode == MODE_ATOMIC) ? CW'(ATOMIC_TICKS) : CW'(SPLIT_TICKS);
      commit_addr <= launch_addr;
      commit_mode <= launch_mode;
      commit_data <= launch_data;
    end else if (busy_q) begin
      if (cnt == CW'(1)) busy_q <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign commit = busy_q && (cnt == CW'(1));

  // R3: a second launch is never accepted while one runs
  p_no_relaunch_r3: assert property (@(posedge clk) disable iff (!por_n)
    launch |-> !busy_q);

  // R5: the reserved mode never reaches the engine
  p_rsvd_blocked_r5: assert property (@(posedge clk) disable iff (!por_n)
    launch |-> (launch_mode != MODE_RSVD));

  // R7: busy holds until the last tick
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!por_n)
    (busy_q && cnt > CW'(1)) |=> busy_q);

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  input  nvm_mode_e     commit_mode,
  input  logic [7:0]    commit_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (commit) begin
      cells[commit_addr] <= apply_op(commit_mode, cells[commit_addr], commit_data);
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int PROG_STALL = 2,
  parameter int READ_STALL = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic prog_evt,
  input  logic read_evt,
  output logic stall
);
  localparam int MAXS = (PROG_STALL > READ_STALL) ? PROG_STALL : READ_STALL;
  localparam int CW   = $clog2(MAXS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (!rst_n)     cnt <= '0;
    else if (read_evt)   cnt <= CW'(READ_STALL);
    else if (prog_evt)   cnt <= CW'(PROG_STALL);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign stall = (cnt != '0);

  // R10: every accepted start or read raises the stall on the next cycle
  p_stall_start_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_evt || read_evt) |=> stall);

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int AW           = 6,
  parameter int ATOMIC_TICKS = 26368,
  parameter int SPLIT_TICKS  = 13960,
  parameter int ARM_WINDOW   = 4,
  parameter int PROG_STALL   = 2,
  parameter int READ_STALL   = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          flash_busy,
  output logic [7:0]    ctrl_q,
  output logic [AW-1:0] addr_q,
  output logic [7:0]    data_q,
  output logic          irq,
  output logic          stall
);

  logic          ctrl_wr, addr_wr, data_wr;
  logic          busy, armed, launch, read_ok, arm_set;
  nvm_mode_e     mode_q;
  logic          rie_q;
  logic [AW-1:0] addr_r;
  logic [7:0]    data_r, cell_rd;
  logic          commit;
  logic [AW-1:0] commit_addr;
  nvm_mode_e     commit_mode;
  logic [7:0]    commit_data;
  logic          unused_hi;

  assign unused_hi = ^reg_wdata[7:6];

  assign ctrl_wr = rst_n && reg_we && (reg_sel == SEL_CTRL);
  assign addr_wr = rst_n && reg_we && (reg_sel == SEL_ADDR);
  assign data_wr = rst_n && reg_we && (reg_sel == SEL_DATA);

  // the mode in force before this write selects the operation
  assign launch  = ctrl_wr && reg_wdata[B_START] && armed && !busy
                   && !flash_busy && (mode_q != MODE_RSVD);
  assign read_ok = ctrl_wr && reg_wdata[B_READ] && !busy;
  assign arm_set = ctrl_wr && reg_wdata[B_ARM];

  // mode and interrupt enable; mode survives a system reset while busy
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_ATOMIC;
      rie_q  <= 1'b0;
    end else if (!rst_n) begin
      rie_q <= 1'b0;
      if (!busy) mode_q <= MODE_ATOMIC;
    end else if (ctrl_wr) begin
      rie_q <= reg_wdata[B_RIE];
      if (!busy) mode_q <= nvm_mode_e'(reg_wdata[B_MHI:B_MLO]);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                addr_r <= '0;
    else if (!rst_n)           addr_r <= '0;
    else if (addr_wr && !busy) addr_r <= reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       data_r <= '0;
    else if (!rst_n)  data_r <= '0;
    else if (read_ok) data_r <= cell_rd;
    else if (data_wr) data_r <= reg_wdata;
  end

  nvm_arm_window #(.WIN(ARM_WINDOW)) u_arm (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .arm_set(arm_set), .consume(launch), .armed(armed)
  );

  nvm_prog_engine #(.ATOMIC_TICKS(ATOMIC_TICKS), .SPLIT_TICKS(SPLIT_TICKS), .AW(AW)) u_engine (
    .clk(clk), .por_n(por_n), .launch(launch), .launch_mode(mode_q),
    .launch_addr(addr_r), .launch_data(data_r), .busy(busy), .commit(commit),
    .commit_addr(commit_addr), .commit_mode(commit_mode), .commit_data(commit_data)
  );

  nvm_cell_array #(.AW(AW)) u_cells (
    .clk(clk), .por_n(por_n), .rd_addr(addr_r), .rd_data(cell_rd),
    .commit(commit), .commit_addr(commit_addr), .commit_mode(commit_mode),
    .commit_data(commit_data)
  );

  nvm_stall_gen #(.PROG_STALL(PROG_STALL), .READ_STALL(READ_STALL)) u_stall (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .prog_evt(launch), .read_evt(read_ok), .stall(stall)
  );

  assign ctrl_q = {2'b00, mode_q, rie_q, armed, busy, 1'b0};
  assign addr_q = addr_r;
  assign data_q = data_r;
  assign irq    = rie_q & ~busy;

  // R6: mode bits frozen while programming
  p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!por_n)
    (busy && reg_we && reg_sel == SEL_CTRL) |=> (mode_q == $past(mode_q)));

  // R8: address register frozen while programming
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!por_n)
    (busy && rst_n && reg_we && reg_sel == SEL_ADDR) |=> (addr_r == $past(addr_r)));

  // R9: flash activity blocks a launch
  p_flash_block_r9: assert property (@(posedge clk) disable iff (!por_n)
    flash_busy |=> !$rose(busy));

  // R11: an enabled interrupt fires when the operation ends
  p_irq_ready_r11: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(busy) && rie_q) |-> irq);

endmodule

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
  localparam int AT = 24;
  localparam int ST = 12;
  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

  // {addr[5:0], mode[1:0], data[7:0], expected byte[7:0]}
  localparam logic [23:0] VEC [8] = '{
    {6'd5,  2'd0, 8'h3C, 8'h3C},
    {6'd5,  2'd2, 8'hF0, 8'h30},
    {6'd5,  2'd1, 8'h00, 8'hFF},
    {6'd5,  2'd2, 8'hA5, 8'hA5},
    {6'd9,  2'd0, 8'h00, 8'h00},
    {6'd9,  2'd2, 8'hFF, 8'h00},
    {6'd63, 2'd0, 8'h81, 8'h81},
    {6'd63, 2'd1, 8'h12, 8'hFF}
  };

  logic clk = 1'b0;
  logic por_n, rst_n, reg_we, flash_busy;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] ctrl_q, data_q;
  logic [5:0] addr_q;
  logic irq, stall;
  int n_run = 0, n_fail = 0;
  logic rie = 1'b0;

  always #10 clk = ~clk;

  nvm_ctrl #(.AW(6), .ATOMIC_TICKS(AT), .SPLIT_TICKS(ST)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .flash_busy(flash_busy), .ctrl_q(ctrl_q), .addr_q(addr_q),
    .data_q(data_q), .irq(irq), .stall(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called on a falling edge; the write lands on the next rising edge
  task automatic reg_wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] cb(logic [1:0] m, logic ie, logic arm, logic st, logic rd);
    return {2'b00, m, ie, arm, st, rd};
  endfunction

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_q[1] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic prog(input logic [5:0] a, input logic [1:0] m, input logic [7:0] d, output int ticks);
    reg_wr(S_ADDR, {2'b00, a});
    reg_wr(S_DATA, d);
    reg_wr(S_CTRL, cb(m, rie, 1'b1, 1'b0, 1'b0));
    reg_wr(S_CTRL, cb(m, rie, 1'b0, 1'b1, 1'b0));
    wait_idle(ticks);
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] m);
    reg_wr(S_ADDR, {2'b00, a});
    reg_wr(S_CTRL, cb(m, rie, 1'b0, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t;
    por_n = 0; rst_n = 0; reg_we = 0; reg_sel = 2'd3; reg_wdata = 0; flash_busy = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 addr", addr_q, 6'd0);
    chk("R1 data", data_q, 8'h00);
    chk("R1 irq/stall", {irq, stall}, 2'b00);
    rd(6'd0, 2'd0);
    chk("R1 erased cell", data_q, 8'hFF);
    repeat (4) @(negedge clk);

    // R3 R4 R7 vector table
    for (int i = 0; i < 8; i++) begin
      prog(VEC[i][23:18], VEC[i][17:16], VEC[i][15:8], t);
      chk("R3 busy ticks", t, (VEC[i][17:16] == 2'd0) ? AT : ST);
      rd(VEC[i][23:18], VEC[i][17:16]);
      chk("R4 stored byte", data_q, VEC[i][7:0]);
      repeat (4) @(negedge clk);
    end

    // R2 arm window, then R3 late start refused
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R2 arm c1", ctrl_q[2], 1'b1);
    for (int k = 0; k < 3; k++) begin @(negedge clk); chk("R2 arm held", ctrl_q[2], 1'b1); end
    @(negedge clk);
    chk("R2 arm expired", ctrl_q[2], 1'b0);
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R3 start without arm", ctrl_q[1], 1'b0);

    // R3 start at last window cycle; R10 R6 R8 R11 R7 during the run
    reg_wr(S_ADDR, 8'd7);
    reg_wr(S_DATA, 8'h5A);
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R3 start at window edge", ctrl_q[1], 1'b1);
    chk("R10 prog stall c1", stall, 1'b1);
    @(negedge clk); chk("R10 prog stall c2", stall, 1'b1);
    @(negedge clk); chk("R10 prog stall end", stall, 1'b0);
    reg_wr(S_CTRL, cb(2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R6 mode frozen", ctrl_q[5:4], 2'd0);
    chk("R11 irq low while busy", irq, 1'b0);
    reg_wr(S_ADDR, 8'd3);
    chk("R8 addr frozen", addr_q, 6'd7);
    reg_wr(S_DATA, 8'h77);
    reg_wr(S_CTRL, cb(2'd0, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R8 read refused", data_q, 8'h77);
    chk("R10 no stall on refused read", stall, 1'b0);
    wait_idle(t);
    chk("R11 irq after done", irq, 1'b1);
    rd(6'd7, 2'd0);
    chk("R7 launch data kept", data_q, 8'h5A);
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R11 irq disabled", irq, 1'b0);

    // R5 reserved mode
    reg_wr(S_CTRL, cb(2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
    reg_wr(S_CTRL, cb(2'd3, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R5 no busy", ctrl_q[1], 1'b0);
    chk("R5 arm kept", ctrl_q[2], 1'b1);
    repeat (5) @(negedge clk);

    // R9 flash busy blocks start
    flash_busy = 1'b1;
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    reg_wr(S_CTRL, cb(2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R9 start blocked", ctrl_q[1], 1'b0);
    flash_busy = 1'b0;
    repeat (5) @(negedge clk);

    // R10 read stall length
    rd(6'd7, 2'd0);
    chk("R10 read stall c1", stall, 1'b1);
    for (int k = 0; k < 3; k++) begin @(negedge clk); chk("R10 read stall held", stall, 1'b1); end
    @(negedge clk); chk("R10 read stall end", stall, 1'b0);

    // R12 system reset during and after a write-only run
    reg_wr(S_DATA, 8'h0F);
    reg_wr(S_CTRL, cb(2'd2, 1'b0, 1'b1, 1'b0, 1'b0));
    reg_wr(S_CTRL, cb(2'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R12 mode kept in reset", ctrl_q[5:4], 2'd2);
    chk("R12 busy kept in reset", ctrl_q[1], 1'b1);
    wait_idle(t);
    rd(6'd7, 2'd2);
    chk("R12 result stored", data_q, 8'h0A);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R12 idle reset mode", ctrl_q, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule